// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the outcome of conditional branches for a small in-order pipeline. It owns the loop counter register and, for each valid branch request, decides from a 5-bit branch-options field, a 5-bit condition-bit selector and the 32-bit condition register whether the branch is taken. It moves the counter down by one when the options ask for it, and it chooses the next fetch address.

The options field can combine a test of one condition bit with a test of the counter. The counter test always looks at the value the counter will hold after the decrement, which is the pre-branch value minus one. Return-style branches redirect to the link register value rather than to the computed target. All results appear one clock after the request, together with a one-cycle strobe.

Top module: `branch_resolver`

## Requirements
- R1: While rst_n is low, and at the first edge after it, resolved and taken are 0 and next_pc and ctr are 0.
- R2: resolved is 1 in exactly the cycle that follows a clock edge at which req_valid was 1, and 0 otherwise.
- R3: The condition bit is cr[31 - bi], so bi = 0 selects the most significant bit of cr.
- R4: Options decode, with bo[4] as the most significant bit: bo[4]=1 skips the condition test; otherwise the condition bit must equal bo[3]. bo[2]=1 skips the counter test; otherwise bo[1]=0 needs ctr-1 ≠ 0 and bo[1]=1 needs ctr-1 = 0. The branch is taken when both tests pass.
- R5: The counter test uses the ctr value held before the request, minus one, and not the updated value.
- R6: On a valid request with bo[2]=0, ctr becomes ctr-1 at the next edge and wraps from 0 to all ones. ctr keeps its value when bo[2]=1 and when there is no request.
- R7: bo[0] never affects taken or ctr. bo[1] has no effect when bo[2]=1, and bo[3] has no effect when bo[4]=1.
- R8: After a request, next_pc is target when the branch is taken and is_return is 0, lr when it is taken and is_return is 1, and pc+4 when it is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch request present this cycle |
| bo | input | 5 | Branch options field |
| bi | input | 5 | Condition-bit selector |
| cr | input | 32 | Condition register |
| is_return | input | 1 | Branch redirects to the link register |
| lr | input | AW | Link register value |
| target | input | AW | Computed branch target |
| pc | input | AW | Address of the branch |
| resolved | output | 1 | One-cycle strobe for a settled request |
| taken | output | 1 | Branch outcome |
| next_pc | output | AW | Next fetch address |
| ctr | output | CW | Loop counter |

## Verification
The bench runs with a 4-bit counter, so it can walk the counter through its wrap and bring it down to exactly one. It then checks that the test for zero after the decrement fires on that count and not on the ones around it, which separates a pre-decrement compare from a post-decrement compare. Single-bit condition words swept over several selectors show whether the bit order is reversed. The same options issued with hint bits flipped, and with don't-care bits set, must give the same result. Back-to-back requests mixed with idle gaps and random options, both plain and return-style, check the strobe and the counter's hold behaviour against a queued model.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [4:0]    bo,
  input  logic [4:0]    bi,
  input  logic [31:0]   cr,
  input  logic          is_return,
  input  logic [AW-1:0] lr,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] pc,
  output logic          resolved,
  output logic          taken,
  output logic [AW-1:0] next_pc,
  output logic [CW-1:0] ctr
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic cond_bit, last_iter, cond_ok, ctr_ok, take, dec;

  assign cond_bit  = cr[5'd31 - bi];
  assign last_iter = (ctr == ONE);
  assign dec       = ~bo[2];
  assign cond_ok   = bo[4] | (cond_bit == bo[3]);
  assign ctr_ok    = bo[2] | (last_iter == bo[1]);
  assign take      = cond_ok & ctr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resolved <= 1'b0;
      taken    <= 1'b0;
      next_pc  <= '0;
      ctr      <= '0;
    end else begin
      resolved <= req_valid;
      if (req_valid) begin
        taken   <= take;
        next_pc <= take ? (is_return ? lr : target) : pc + AW'(4);
        if (dec) ctr <= ctr - ONE;
      end
    end
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [4:0]    bo,
  input logic          is_return,
  input logic [AW-1:0] lr,
  input logic [AW-1:0] pc,
  input logic          resolved,
  input logic          taken,
  input logic [AW-1:0] next_pc,
  input logic [CW-1:0] ctr
);
  // R2
  strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resolved);
  // R2
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resolved);
  // R6
  ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bo[2]) |=> ctr == $past(ctr) - CW'(1));
  // R6
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || bo[2]) |=> $stable(ctr));
  // R4
  always_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bo[4] && bo[2]) |=> taken);
  // R8
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid) |=> (taken || next_pc == $past(pc) + AW'(4)));
  // R8
  return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_return) |=> (!taken || next_pc == $past(lr)));
endmodule

bind branch_resolver branch_resolver_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bo(bo),
  .is_return(is_return), .lr(lr), .pc(pc), .resolved(resolved),
  .taken(taken), .next_pc(next_pc), .ctr(ctr)
);

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;
  localparam int AW = 32;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, req_valid = 0, is_return = 0;
  logic [4:0] bo = '0, bi = '0;
  logic [31:0] cr = '0;
  logic [AW-1:0] lr = '0, target = '0, pc = '0;
  logic resolved, taken;
  logic [AW-1:0] next_pc;
  logic [CW-1:0] ctr;

  branch_resolver #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bo(bo), .bi(bi), .cr(cr),
    .is_return(is_return), .lr(lr), .target(target), .pc(pc),
    .resolved(resolved), .taken(taken), .next_pc(next_pc), .ctr(ctr));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [CW-1:0] model_ctr = '0;
  logic          q_taken[$];
  logic [AW-1:0] q_pc[$];
  logic [CW-1:0] q_ctr[$];
  string         q_tag[$];
  bit done = 0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic predict(logic [4:0] o, logic [4:0] s, logic [31:0] c, logic [CW-1:0] cv);
    logic cb, cok, kok;
    cb  = c[31 - s];
    cok = o[4] ? 1'b1 : (o[3] ? cb : !cb);
    kok = o[2] ? 1'b1 : (o[1] ? (cv - CW'(1)) == '0 : (cv - CW'(1)) != '0);
    return cok & kok;
  endfunction

  task automatic send(logic [4:0] o, logic [4:0] s, logic [31:0] c, logic ret,
                      logic [AW-1:0] l, logic [AW-1:0] t, logic [AW-1:0] p, string tag);
    logic tk;
    @(negedge clk);
    req_valid = 1; bo = o; bi = s; cr = c; is_return = ret; lr = l; target = t; pc = p;
    tk = predict(o, s, c, model_ctr);
    if (!o[2]) model_ctr = model_ctr - CW'(1);
    q_taken.push_back(tk);
    q_pc.push_back(tk ? (ret ? l : t) : p + 32'd4);
    q_ctr.push_back(model_ctr);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
      bo = 5'b00000;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resolved) begin
        if (q_taken.size() == 0) check(0, "R2 strobe without request", 1, 0);
        else begin
          logic et; logic [AW-1:0] ep; logic [CW-1:0] ec; string tg;
          et = q_taken.pop_front(); ep = q_pc.pop_front();
          ec = q_ctr.pop_front(); tg = q_tag.pop_front();
          check(taken == et, {tg, " taken"}, 64'(taken), 64'(et));
          check(next_pc == ep, {"R8 next_pc ", tg}, 64'(next_pc), 64'(ep));
          check(ctr == ec, {"R6 ctr ", tg}, 64'(ctr), 64'(ec));
        end
      end else if (q_taken.size() != 0 && !req_valid) begin
        check(0, "R2 missing strobe", 0, 1);
      end else if (!resolved && !req_valid) begin
        check(ctr == model_ctr, "R6 ctr hold while idle", 64'(ctr), 64'(model_ctr));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(resolved == 0 && taken == 0, "R1 reset flags", {resolved, taken}, 0);
    check(next_pc == 0 && ctr == 0, "R1 reset regs", 64'(next_pc) | 64'(ctr), 0);
    rst_n = 1;
    @(negedge clk);
    check(resolved == 0 && ctr == 0, "R1 after release", 64'(ctr), 0);

    // R4 always branch, R7 hint bits
    send(5'b10100, 0, 0, 0, 32'h500, 32'h1000, 32'h100, "R4 always");
    send(5'b11111, 3, 0, 0, 32'h500, 32'h1004, 32'h104, "R7 always hints");
    // R6 wrap 0 -> F
    send(5'b10000, 0, 0, 0, 32'h500, 32'h2000, 32'h200, "R6 wrap nonzero");
    idle(2);
    // R5 zero test after decrement: walk down to one
    send(5'b10010, 0, 0, 0, 0, 32'h3000, 32'h300, "R5 zero test not yet");
    while (model_ctr != CW'(1)) send(5'b10000, 0, 0, 0, 0, 32'h3100, 32'h310, "R5 walk");
    send(5'b10010, 0, 0, 0, 0, 32'h3200, 32'h320, "R5 zero reached");
    send(5'b10000, 0, 0, 0, 0, 32'h3300, 32'h330, "R5 from zero");
    idle(1);
    // R3 bit selection
    for (int s = 0; s < 32; s += 5) begin
      send(5'b01100, 5'(s), 32'h8000_0000 >> s, 0, 0, 32'h4000, 32'h400, "R3 selected bit set");
      send(5'b01100, 5'(s), ~(32'h8000_0000 >> s), 0, 0, 32'h4100, 32'h410, "R3 selected bit clear");
      send(5'b00100, 5'(s), 32'h8000_0000 >> s, 0, 0, 32'h4200, 32'h420, "R3 false sense");
    end
    // R7 hints on conditional-only
    send(5'b01111, 2, 32'h2000_0000, 0, 0, 32'h5000, 32'h500, "R7 hint true");
    send(5'b00111, 2, 32'h2000_0000, 0, 0, 32'h5100, 32'h510, "R7 hint false");
    // R4 combined cond and ctr
    send(5'b01000, 1, 32'h4000_0000, 0, 0, 32'h6000, 32'h600, "R4 cond and ctr");
    send(5'b00001, 1, 32'h4000_0000, 0, 0, 32'h6100, 32'h610, "R4 false and ctr");
    // R8 return
    send(5'b10100, 0, 0, 1, 32'h7770, 32'h7000, 32'h700, "R8 return");
    send(5'b01100, 0, 0, 1, 32'h7774, 32'h7100, 32'h710, "R8 return not taken");
    idle(3);
    for (int i = 0; i < 300; i++) begin
      send(5'($urandom), 5'($urandom), $urandom, 1'($urandom), $urandom & 32'hFFFF_FFFC,
           $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, "R4 random");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule